// File: doc/BRIEF.md
# Serial SAR-ADC Host Controller

This block is the host side of a four-wire serial link to a 14-bit successive-approximation converter. The link has an active-low select, a serial clock, a host-to-converter data line and a converter-to-host data line. A fifth input carries the converter's end-of-conversion strobe. For each accepted request the controller shifts out an 8-bit control word, then completes the conversion in one of two ways. In the self-clocked mode the host supplies every clock of a 24-clock frame. In the strobe mode it parks the serial clock low, waits for the converter to signal completion, and then clocks the result out.

The returned sample is delivered as a zero-extended unsigned value or a sign-extended signed value, depending on the polarity the request selected. Two divider parameters set the serial clock period. The control-word clocks use a slower setting, which gives the converter enough acquisition time. The data clocks use a faster setting. In the self-clocked mode the frame may be split into three 8-clock bytes, with select raised between them. A timeout bounds the wait for the strobe.

Top module: `sar_link_host`

## Requirements
- R1: The control word is sent most significant bit first on the first 8 serial clocks. Bit 7 is 1 (start). Bit 6 is 1 for unipolar and 0 for bipolar. Bit 5 is 1 for strobe mode. Bits 4:3 are `reqMode`. Bits 2:0 are `reqPins`. `mosi` changes only while `sclk` is low and is 0 on every later rising edge.
- R2: In self-clocked mode a frame has exactly 24 serial clock pulses. The result bits B13 down to B0 are taken on rising edges 9 to 22. The data on rising edges 23 and 24 is discarded. `sclk` is low whenever `csN` is high.
- R3: In strobe mode, after the 8th falling edge `sclk` stays low and `csN` stays low until a rising edge of `strobe` is seen. Then 16 more clocks follow, and B13 is taken on the first rising edge.
- R4: In self-clocked mode the `strobe` input has no effect on the frame, the result or the error flag.
- R5: For a unipolar request `result` is the 14-bit sample zero-extended to the output width. For a bipolar request it is sign-extended from B13.
- R6: If no `strobe` rise is seen within `TIMEOUT_CYC` system clocks after the 8th falling edge, the frame ends. `csN` goes high, `done` pulses with `timeoutErr` set, and `result` keeps its old value. `timeoutErr` clears when the next request is accepted.
- R7: Each phase of the 8 control-word clocks lasts `HALF_WR` system clocks. Each phase of the later clocks lasts `HALF_RD` system clocks.
- R8: When `reqSplit` is set in self-clocked mode, `csN` rises for `GAP_CYC` system clocks after clocks 8 and 16, with no clock pulses during the gap, and the frame then continues. `reqSplit` has no effect in strobe mode.
- R9: A request is taken when `reqValid` is high and `busy` is low. `busy` then stays high until the frame ends. `done` is a one-cycle pulse in the first cycle with `busy` low. `reqValid` is ignored while `busy` is high.
- R10: After reset `csN` is 1, and `sclk`, `mosi`, `busy`, `done`, `timeoutErr` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a conversion |
| reqBipolar | input | 1 | 1 = signed conversion |
| reqIntClk | input | 1 | 1 = strobe mode, 0 = self-clocked |
| reqMode | input | 2 | Converter mode bits |
| reqPins | input | 3 | Values for the converter's user output pins |
| reqSplit | input | 1 | Send the self-clocked frame as three bytes |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| result | output | OUT_W | Formatted sample |
| timeoutErr | output | 1 | Strobe wait expired |
| csN | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Host-to-converter data |
| miso | input | 1 | Converter-to-host data |
| strobe | input | 1 | Converter end-of-conversion strobe |

## Verification
The checker watches a fixed set of rules on every cycle. `mosi` holds steady while `sclk` is high, `sclk` is low whenever select is high, and the link stays parked during the strobe wait. The done/busy pulse shape and the extension of the result's upper bits are also checked each cycle. Some properties can only be shown by the bench's converter model, which works through whole frames: the decoded control word, the bit alignment of the returned sample, the number of clocks and their phase widths, the select gaps of split frames, immunity to a noisy strobe in self-clocked mode, and the timeout path.

// File: rtl/sar_link_pkg.sv
package sar_link_pkg;
  localparam int FRAME_CLKS = 24;
  localparam int BYTE_CLKS  = 8;
  localparam int FIRST_DATA = 8;

  typedef enum logic [2:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_GAP, ST_WAIT} linkState_t;

  typedef struct packed {
    logic load;
    logic rise;
    logic fall;
    logic capture;
    logic finish;
  } linkStrobes_t;

  function automatic logic [7:0] buildCtl(input logic bipolar, input logic intClk,
                                          input logic [1:0] mode, input logic [2:0] pins);
    return {1'b1, ~bipolar, intClk, mode, pins};
  endfunction
endpackage

// File: rtl/sar_link_ctrl.sv
module sar_link_ctrl
  import sar_link_pkg::*;
#(
  parameter int HALF_WR     = 14,
  parameter int HALF_RD     = 8,
  parameter int GAP_CYC     = 16,
  parameter int TIMEOUT_CYC = 750,
  parameter int RES_W       = 14
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqIntClk,
  input  logic         reqSplit,
  input  logic         strobeRise,
  output linkStrobes_t stb,
  output logic         csN,
  output logic         busy,
  output logic         done,
  output logic         timeoutErr,
  output logic         waiting
);
  localparam int MAX_A = (HALF_WR > HALF_RD) ? HALF_WR : HALF_RD;
  localparam int MAX_P = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int PH_W  = $clog2(MAX_P + 1);
  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int IDX_W = $clog2(FRAME_CLKS);

  linkState_t state, stateNext;
  logic [PH_W-1:0]  phaseCnt, phaseNext, halfLen;
  logic [IDX_W-1:0] clkIdx, clkIdxNext;
  logic [TO_W-1:0]  timer, timerNext;
  logic intMode, splitMode, timeoutHit;
  logic phaseEnd, lastClk, pauseSplit, inData;

  assign halfLen    = (clkIdx < IDX_W'(BYTE_CLKS)) ? PH_W'(HALF_WR) : PH_W'(HALF_RD);
  assign phaseEnd   = (phaseCnt == halfLen - PH_W'(1));
  assign lastClk    = (clkIdx == IDX_W'(FRAME_CLKS - 1));
  assign pauseSplit = splitMode && !intMode &&
                      (clkIdx == IDX_W'(BYTE_CLKS - 1) || clkIdx == IDX_W'(2 * BYTE_CLKS - 1));
  assign inData     = (clkIdx >= IDX_W'(FIRST_DATA)) && (clkIdx < IDX_W'(FIRST_DATA + RES_W));
  assign waiting    = (state == ST_WAIT);

  always_comb begin
    stateNext  = state;
    phaseNext  = phaseCnt;
    clkIdxNext = clkIdx;
    timerNext  = timer;
    stb        = '0;
    timeoutHit = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        stateNext  = ST_LOW;
        phaseNext  = '0;
        clkIdxNext = '0;
        stb.load   = 1'b1;
      end
      ST_LOW: if (phaseEnd) begin
        stateNext   = ST_HIGH;
        phaseNext   = '0;
        stb.rise    = 1'b1;
        stb.capture = inData;
      end else phaseNext = phaseCnt + PH_W'(1);
      ST_HIGH: if (phaseEnd) begin
        stb.fall  = 1'b1;
        phaseNext = '0;
        if (lastClk) begin
          stateNext  = ST_IDLE;
          stb.finish = 1'b1;
        end else begin
          clkIdxNext = clkIdx + IDX_W'(1);
          if (intMode && clkIdx == IDX_W'(BYTE_CLKS - 1)) begin
            stateNext = ST_WAIT;
            timerNext = '0;
          end else if (pauseSplit) stateNext = ST_GAP;
          else stateNext = ST_LOW;
        end
      end else phaseNext = phaseCnt + PH_W'(1);
      ST_GAP: if (phaseCnt == PH_W'(GAP_CYC - 1)) begin
        stateNext = ST_LOW;
        phaseNext = '0;
      end else phaseNext = phaseCnt + PH_W'(1);
      ST_WAIT: if (strobeRise) begin
        stateNext = ST_LOW;
        phaseNext = '0;
      end else if (timer == TO_W'(TIMEOUT_CYC - 1)) begin
        stateNext  = ST_IDLE;
        timeoutHit = 1'b1;
      end else timerNext = timer + TO_W'(1);
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phaseCnt   <= '0;
      clkIdx     <= '0;
      timer      <= '0;
      intMode    <= 1'b0;
      splitMode  <= 1'b0;
      csN        <= 1'b1;
      busy       <= 1'b0;
      done       <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      state    <= stateNext;
      phaseCnt <= phaseNext;
      clkIdx   <= clkIdxNext;
      timer    <= timerNext;
      if (stb.load) begin
        intMode   <= reqIntClk;
        splitMode <= reqSplit;
      end
      csN  <= !(stateNext inside {ST_LOW, ST_HIGH, ST_WAIT});
      busy <= (stateNext != ST_IDLE);
      done <= stb.finish | timeoutHit;
      if (stb.load) timeoutErr <= 1'b0;
      else if (timeoutHit) timeoutErr <= 1'b1;
    end
  end
endmodule

// File: rtl/sar_link_dp.sv
module sar_link_dp
  import sar_link_pkg::*;
#(
  parameter int RES_W = 14,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  linkStrobes_t     stb,
  input  logic [7:0]       ctlByte,
  input  logic             reqBipolar,
  input  logic             miso,
  input  logic             strobe,
  output logic             sclk,
  output logic             mosi,
  output logic             strobeRise,
  output logic             bipolarQ,
  output logic [OUT_W-1:0] result
);
  logic [7:0]       txShift;
  logic [RES_W-1:0] rxShift;
  logic [1:0]       strobeSync;
  logic             strobePrev;
  logic [OUT_W-1:0] formatted;

  generate
    if (OUT_W > RES_W) begin : g_extend
      assign formatted = {{(OUT_W - RES_W){bipolarQ & rxShift[RES_W-1]}}, rxShift};
    end else begin : g_plain
      assign formatted = rxShift;
    end
  endgenerate

  assign mosi       = txShift[7];
  assign strobeRise = strobeSync[1] & ~strobePrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift    <= '0;
      rxShift    <= '0;
      sclk       <= 1'b0;
      bipolarQ   <= 1'b0;
      result     <= '0;
      strobeSync <= '0;
      strobePrev <= 1'b0;
    end else begin
      strobeSync <= {strobeSync[0], strobe};
      strobePrev <= strobeSync[1];
      if (stb.load) begin
        txShift  <= ctlByte;
        bipolarQ <= reqBipolar;
      end else if (stb.fall) begin
        txShift <= {txShift[6:0], 1'b0};
      end
      if (stb.rise) sclk <= 1'b1;
      else if (stb.fall) sclk <= 1'b0;
      if (stb.capture) rxShift <= {rxShift[RES_W-2:0], miso};
      if (stb.finish) result <= formatted;
    end
  end
endmodule

// File: rtl/sar_link_host.sv
module sar_link_host
  import sar_link_pkg::*;
#(
  parameter int HALF_WR     = 14,
  parameter int HALF_RD     = 8,
  parameter int GAP_CYC     = 16,
  parameter int TIMEOUT_CYC = 750,
  parameter int RES_W       = 14,
  parameter int OUT_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqBipolar,
  input  logic             reqIntClk,
  input  logic [1:0]       reqMode,
  input  logic [2:0]       reqPins,
  input  logic             reqSplit,
  output logic             busy,
  output logic             done,
  output logic [OUT_W-1:0] result,
  output logic             timeoutErr,
  output logic             csN,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  input  logic             strobe
);
  linkStrobes_t stb;
  logic strobeRise, waiting, bipolarQ;
  logic [7:0] ctlByte;

  assign ctlByte = buildCtl(reqBipolar, reqIntClk, reqMode, reqPins);

  sar_link_ctrl #(
    .HALF_WR(HALF_WR), .HALF_RD(HALF_RD), .GAP_CYC(GAP_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC), .RES_W(RES_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIntClk(reqIntClk),
    .reqSplit(reqSplit), .strobeRise(strobeRise), .stb(stb), .csN(csN),
    .busy(busy), .done(done), .timeoutErr(timeoutErr), .waiting(waiting)
  );

  sar_link_dp #(.RES_W(RES_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ctlByte(ctlByte), .reqBipolar(reqBipolar),
    .miso(miso), .strobe(strobe), .sclk(sclk), .mosi(mosi),
    .strobeRise(strobeRise), .bipolarQ(bipolarQ), .result(result)
  );
endmodule

// File: rtl/sar_link_checks.sv
module sar_link_checks #(
  parameter int RES_W = 14,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             sclk,
  input logic             mosi,
  input logic             busy,
  input logic             done,
  input logic             timeoutErr,
  input logic [OUT_W-1:0] result,
  input logic             waiting,
  input logic             bipolarQ
);
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(mosi)); // R1
  AST_SCLK_LOW_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R2
  AST_WAIT_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    waiting |-> (!sclk && !csN)); // R3
  AST_SIGN_EXTEND: assert property (@(posedge clk) disable iff (!rstN)
    (done && bipolarQ && !timeoutErr) |->
      (result[OUT_W-1:RES_W] == {(OUT_W-RES_W){result[RES_W-1]}})); // R5
  AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rstN)
    (done && !bipolarQ && !timeoutErr) |-> (result[OUT_W-1:RES_W] == '0)); // R5
  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> done); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R9
  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN); // R9
endmodule

bind sar_link_host sar_link_checks #(.RES_W(RES_W), .OUT_W(OUT_W)) u_checks (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .busy(busy),
  .done(done), .timeoutErr(timeoutErr), .result(result), .waiting(waiting),
  .bipolarQ(bipolarQ)
);

// File: tb/sar_link_host_bench.sv
module sar_link_host_bench;
  localparam int RES_W = 14, OUT_W = 16, HALF_WR = 14, HALF_RD = 8;
  localparam int GAP_CYC = 16, TIMEOUT_CYC = 750;

  logic clk = 1'b0, rstN = 1'b0;
  always #4 clk = ~clk;

  logic reqValid = 1'b0, reqBipolar = 1'b0, reqIntClk = 1'b0, reqSplit = 1'b0;
  logic [1:0] reqMode = '0;
  logic [2:0] reqPins = '0;
  logic busy, done, timeoutErr, csN, sclk, mosi;
  logic [OUT_W-1:0] result;
  logic miso, strobe;

  sar_link_host #(.HALF_WR(HALF_WR), .HALF_RD(HALF_RD), .GAP_CYC(GAP_CYC),
                  .TIMEOUT_CYC(TIMEOUT_CYC), .RES_W(RES_W), .OUT_W(OUT_W)) u_sar_link_host (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBipolar(reqBipolar),
    .reqIntClk(reqIntClk), .reqMode(reqMode), .reqPins(reqPins), .reqSplit(reqSplit),
    .busy(busy), .done(done), .result(result), .timeoutErr(timeoutErr), .csN(csN),
    .sclk(sclk), .mosi(mosi), .miso(miso), .strobe(strobe));

  int vectors = 0, fails = 0;
  logic wdFired = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    wdFired = 1'b1;
  end

  // converter model configuration (written by the stimulus only)
  logic mExt = 1'b1;
  logic [RES_W-1:0] mData = '0;
  int mDelay = 10;

  // converter model state
  logic sclkQ, csQ, mosiBad, convActive;
  logic [7:0] ctlSeen;
  int riseCnt, fallCnt, hiCnt, wrW, rdW, csRises, riseLow, convCnt;

  always @(posedge clk) begin
    if (!rstN) begin
      sclkQ <= 1'b0; csQ <= 1'b1; mosiBad <= 1'b0; convActive <= 1'b0;
      ctlSeen <= '0; riseCnt <= 0; fallCnt <= 0; hiCnt <= 0; wrW <= 0; rdW <= 0;
      csRises <= 0; riseLow <= 0; convCnt <= 0; strobe <= 1'b1; miso <= 1'b0;
    end else begin
      sclkQ <= sclk;
      csQ   <= csN;
      hiCnt <= sclk ? hiCnt + 1 : 0;
      if (mExt) strobe <= 1'($urandom % 2);
      if (reqValid && !busy) begin
        riseCnt <= 0; fallCnt <= 0; csRises <= 0; riseLow <= 0; mosiBad <= 1'b0;
        ctlSeen <= '0; convActive <= 1'b0; miso <= 1'b0; wrW <= 0; rdW <= 0;
        if (!mExt) strobe <= 1'b1;
      end else begin
        if (!csQ && sclk && !sclkQ) begin
          if (riseCnt < 8) ctlSeen <= {ctlSeen[6:0], mosi};
          else if (mosi) mosiBad <= 1'b1;
          if (!mExt && !strobe) riseLow <= riseLow + 1;
          riseCnt <= riseCnt + 1;
        end
        if (!csQ && !sclk && sclkQ) begin
          if (fallCnt == 0) wrW <= hiCnt;
          if (fallCnt == 12) rdW <= hiCnt;
          fallCnt <= fallCnt + 1;
          if (!mExt && fallCnt == 7) begin
            strobe <= 1'b0; miso <= 1'b0; convActive <= 1'b1; convCnt <= 0;
          end else if (fallCnt >= 7 && fallCnt <= 20) miso <= mData[20 - fallCnt];
          else miso <= 1'b0;
        end
        if (csN && !csQ && busy) csRises <= csRises + 1;
        if (convActive) begin
          if (convCnt == mDelay - 1) begin
            strobe <= 1'b1; miso <= mData[RES_W-1]; convActive <= 1'b0;
          end else convCnt <= convCnt + 1;
        end
      end
    end
  end

  function automatic logic [OUT_W-1:0] expRes(input logic bip, input logic [RES_W-1:0] d);
    return bip ? {{(OUT_W-RES_W){d[RES_W-1]}}, d} : {{(OUT_W-RES_W){1'b0}}, d};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic runFrame(input logic bip, input logic intc, input logic [1:0] mode,
                          input logic [2:0] pins, input logic split,
                          input logic [RES_W-1:0] data, input int delay, input logic noise);
    logic [OUT_W-1:0] prevRes;
    logic expTo;
    if (wdFired) return;
    prevRes = result;
    expTo = intc && (delay > TIMEOUT_CYC);
    mExt = !intc; mData = data; mDelay = delay;
    @(negedge clk);
    reqBipolar = bip; reqIntClk = intc; reqMode = mode; reqPins = pins; reqSplit = split;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9 busy after accept", int'(busy), 1);
    if (noise) begin
      repeat (30) @(negedge clk);
      reqValid = 1'b1; reqIntClk = !intc; reqPins = ~pins; reqBipolar = !bip;
      repeat (20) @(negedge clk);
      reqValid = 1'b0;
    end
    while (!done && !wdFired) @(negedge clk);
    chk("R9 done with busy low", int'(busy), 0);
    chk("R1 control word", int'(ctlSeen), int'({1'b1, ~bip, intc, mode, pins}));
    chk("R7 control clock phase", wrW, HALF_WR);
    if (expTo) begin
      chk("R6 timeout flag", int'(timeoutErr), 1);
      chk("R6 result kept", int'(result), int'(prevRes));
      chk("R6 clocks before abort", riseCnt, 8);
      chk("R6 select released", int'(csN), 1);
    end else begin
      chk(intc ? "R3 strobe-mode result" : "R2 self-clocked result",
          int'(result), int'(expRes(bip, data)));
      chk("R5 extension", int'(result[OUT_W-1:RES_W]),
          int'(expRes(bip, data) >> RES_W));
      chk(intc ? "R6 flag clear" : "R4 strobe ignored", int'(timeoutErr), 0);
      chk("R2 clock count", riseCnt, 24);
      chk("R1 mosi idle low", int'(mosiBad), 0);
      chk("R7 data clock phase", rdW, HALF_RD);
      chk("R8 select gaps", csRises, (split && !intc) ? 2 : 0);
      if (intc) chk("R3 no clock during conversion", riseLow, 0);
    end
    if (noise) begin
      repeat (10) @(negedge clk);
      chk("R9 request ignored while busy", int'(busy), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 csN", int'(csN), 1);
    chk("R10 sclk", int'(sclk), 0);
    chk("R10 mosi", int'(mosi), 0);
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 result", int'(result), 0);
    chk("R10 timeoutErr", int'(timeoutErr), 0);

    runFrame(1'b0, 1'b0, 2'b01, 3'b101, 1'b0, 14'h3FFF, 10, 1'b0);
    runFrame(1'b1, 1'b0, 2'b10, 3'b010, 1'b1, 14'h2000, 10, 1'b0);
    runFrame(1'b1, 1'b1, 2'b11, 3'b111, 1'b0, 14'h1FFF, 40, 1'b0);
    runFrame(1'b0, 1'b1, 2'b00, 3'b000, 1'b1, 14'h0000, 5, 1'b0);
    runFrame(1'b1, 1'b1, 2'b01, 3'b001, 1'b0, 14'h2AAA, 700, 1'b0);
    runFrame(1'b1, 1'b1, 2'b10, 3'b100, 1'b0, 14'h1234, 100000, 1'b0);
    runFrame(1'b0, 1'b0, 2'b00, 3'b011, 1'b0, 14'h0ABC, 10, 1'b1);
    runFrame(1'b1, 1'b1, 2'b11, 3'b110, 1'b0, 14'h3001, 60, 1'b1);

    for (int i = 0; i < 40; i++) begin
      logic intc;
      intc = 1'($urandom % 2);
      runFrame(1'($urandom % 2), intc, 2'($urandom % 4), 3'($urandom % 8),
               1'($urandom % 2), 14'($urandom), 5 + int'($urandom % 500), 1'b0);
    end

    if (wdFired) begin
      fails++; vectors++;
      $display("FAIL watchdog: actual expired expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule